// File: doc/BRIEF.md
# Systolic 3x3 Matrix Multiplier

This block multiplies two square matrices of unsigned integers on a grid of multiply-accumulate cells. Each cell stays in place and keeps one result. Its operands flow through it. Values of the left-hand matrix enter the grid on the west edge and move one cell east on each clock. Values of the right-hand matrix are held as columns, so the matrix is stored transposed. They enter on the north edge and move one cell south on each clock. Every lane is delayed by its index, so the matching operand pairs meet in the right cell on the right cycle. Each cell forms its product with a column-compression (Dadda) reduction tree and then a single two-row adder.

A caller places both matrices on the input buses and pulses `start`. The block copies the operands and clears every accumulator. It then runs for a fixed number of cycles, drops `busy` and raises `done`. The nine results stay on `c_flat` until the next accepted start.

Top module: `sysmm_array`

## Requirements
- R1: While `rst` is high, the edge after it leaves `busy` low, `done` low and every result field at zero.
- R2: Element (r,c) of the left matrix is at `a_flat[(r*3+c)*4 +: 4]`. Element (r,c) of the right matrix is at `b_flat[(r*3+c)*4 +: 4]`. Both are unsigned.
- R3: When `done` is high, the field `c_flat[(r*3+c)*10 +: 10]` holds the exact sum over k of A(r,k)*B(k,c). This holds for every operand value, including all elements equal to 15, which gives 675.
- R4: A start that is accepted clears all nine accumulators in that same edge. On the first busy cycle, every result field reads zero.
- R5: Suppose a start is accepted at edge k. Then `busy` is high from edge k until edge k+7, and `done` rises at edge k+7 (3*3-2 = 7 busy cycles).
- R6: `busy` and `done` are never high together. Once `done` is high, it stays high until the next accepted start.
- R7: While `done` is high and `start` is low, `c_flat` does not change.
- R8: A `start` pulse while `busy` is high is ignored. The run in progress keeps its operands and its timing.
- R9: The operands are captured at the accepting edge. Later changes on `a_flat` or `b_flat` have no effect on the result.
- R10: Each cell's multiplier gives the exact 8-bit product for all 256 pairs of 4-bit operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply. Accepted only when `busy` is low |
| a_flat | input | 36 | Left matrix, row-major, 4 bits per element |
| b_flat | input | 36 | Right matrix, row-major, 4 bits per element |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | The results on `c_flat` are complete |
| c_flat | output | 90 | Product matrix, row-major, 10 bits per element |

## Verification
A skew lane that is off by one cycle pairs A(r,k) with B(k±1,c). The fault reaches the port as a wrong sum in whole rows or columns of `c_flat` when `done` rises, seven cycles after the start. The bench therefore feeds asymmetric matrices. It also multiplies by the identity on either side, so that a swapped or transposed lane is not hidden by symmetry. A fault in one column of a reduction tree shows up only for certain operand pairs. A sweep of all 256 pairs through every cell exposes such a fault within one run. A step counter that is off by one moves the rise of `done` by one cycle, and the latency check catches that. A missing accumulator clear appears as stale sums on the second run.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;

    parameter int DIM_DEF    = 3;
    parameter int ELEM_W_DEF = 4;

    typedef enum logic [1:0] {
        SM_IDLE = 2'd0,
        SM_RUN  = 2'd1,
        SM_DONE = 2'd2
    } sm_state_e;

    typedef logic [7:0] step_t;

    typedef struct packed {
        logic  clear;
        logic  busy;
        logic  done;
        step_t step;
    } ctrl_s;

    // accumulator width: product width plus growth for DIM terms
    function automatic int acc_width(input int w, input int n);
        return 2 * w + $clog2(n);
    endfunction

    // number of cycles the grid needs so the last pair meets in the far corner
    function automatic int run_cycles(input int n);
        return 3 * n - 2;
    endfunction

endpackage

// File: rtl/sysmm_dadda.sv
module sysmm_dadda #(
    parameter int W = 4
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    localparam int PW   = 2 * W;
    localparam int HMAX = W + 1;
    localparam int NT   = 10;

    function automatic logic [PW-1:0] reduce_mul(input logic [W-1:0] xa, input logic [W-1:0] ya);
        logic [HMAX-1:0] col [PW];
        logic [HMAX-1:0] nc  [PW];
        int              ht  [PW];
        int              nh  [PW];
        int              tgt [NT];
        logic [HMAX-1:0] win;
        logic [PW-1:0]   row0;
        logic [PW-1:0]   row1;
        logic            so;
        logic            co;
        int              idx;
        int              rem;
        for (int c = 0; c < PW; c++) begin
            col[c] = '0;
            ht[c]  = 0;
        end
        // partial product dots
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                col[i+j] = col[i+j] | (HMAX'(xa[i] & ya[j]) << ht[i+j]);
                ht[i+j]  = ht[i+j] + 1;
            end
        end
        // target height sequence 2,3,4,6,9,...
        tgt[0] = 2;
        for (int t = 1; t < NT; t++) tgt[t] = (tgt[t-1] * 3) / 2;
        for (int s = NT - 1; s >= 0; s--) begin
            if (tgt[s] < W) begin
                for (int c = 0; c < PW; c++) begin
                    nc[c] = '0;
                    nh[c] = 0;
                end
                for (int c = 0; c < PW; c++) begin
                    idx = 0;
                    for (int k = 0; k < HMAX; k++) begin
                        rem = ht[c] - idx;
                        if ((rem + nh[c] > tgt[s]) && (rem >= 2)) begin
                            win = col[c] >> idx;
                            if ((rem + nh[c] - tgt[s] >= 2) && (rem >= 3)) begin
                                {co, so} = {1'b0, win[0]} + {1'b0, win[1]} + {1'b0, win[2]};
                                idx = idx + 3;
                            end else begin
                                {co, so} = {1'b0, win[0]} + {1'b0, win[1]};
                                idx = idx + 2;
                            end
                            nc[c] = nc[c] | (HMAX'(so) << nh[c]);
                            nh[c] = nh[c] + 1;
                            if (c + 1 < PW) begin
                                nc[c+1] = nc[c+1] | (HMAX'(co) << nh[c+1]);
                                nh[c+1] = nh[c+1] + 1;
                            end
                        end
                    end
                    win = col[c] >> idx;
                    for (int k = 0; k < HMAX; k++) begin
                        if (k < ht[c] - idx) begin
                            nc[c] = nc[c] | (HMAX'(win[0]) << nh[c]);
                            nh[c] = nh[c] + 1;
                        end
                        win = win >> 1;
                    end
                end
                for (int c = 0; c < PW; c++) begin
                    col[c] = nc[c];
                    ht[c]  = nh[c];
                end
            end
        end
        for (int c = 0; c < PW; c++) begin
            row0[c] = col[c][0];
            row1[c] = col[c][1];
        end
        return row0 + row1;
    endfunction

    always_comb p = reduce_mul(x, y);

endmodule

// File: rtl/sysmm_pe.sv
module sysmm_pe #(
    parameter int W  = 4,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    output logic [AW-1:0] acc
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;

    sysmm_dadda #(.W(W)) u_mul (
        .x (a_in),
        .y (b_in),
        .p (prod)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + {{(AW-PW){1'b0}}, prod};
        end
    end

endmodule

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl
    import sysmm_pkg::*;
#(
    parameter int N = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output ctrl_s ctl
);
    localparam int LAST = run_cycles(N) - 1;

    sm_state_e st;
    step_t     step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SM_IDLE;
            step_q <= '0;
        end else begin
            case (st)
                SM_RUN: begin
                    if (step_q == step_t'(LAST)) begin
                        st     <= SM_DONE;
                        step_q <= '0;
                    end else begin
                        step_q <= step_q + step_t'(1);
                    end
                end
                default: begin
                    if (start) begin
                        st     <= SM_RUN;
                        step_q <= '0;
                    end
                end
            endcase
        end
    end

    always_comb begin
        ctl.busy  = (st == SM_RUN);
        ctl.done  = (st == SM_DONE);
        ctl.clear = start && (st != SM_RUN);
        ctl.step  = step_q;
    end

endmodule

// File: rtl/sysmm_feeder.sv
module sysmm_feeder
    import sysmm_pkg::*;
#(
    parameter int N = 3,
    parameter int W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  run,
    input  step_t                 step,
    input  logic [N*N*W-1:0]      a_flat,
    input  logic [N*N*W-1:0]      b_flat,
    output logic [N-1:0][W-1:0]   a_edge,
    output logic [N-1:0][W-1:0]   b_edge
);
    // a_q[row][k]; bt_q[col][k] holds the right matrix transposed
    logic [N-1:0][N-1:0][W-1:0] a_q;
    logic [N-1:0][N-1:0][W-1:0] bt_q;
    logic [N-1:0][N-1:0][W-1:0] b_in;

    assign b_in = b_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            bt_q <= '0;
        end else if (load) begin
            a_q <= a_flat;
            for (int j = 0; j < N; j++) begin
                for (int k = 0; k < N; k++) begin
                    bt_q[j][k] <= b_in[k][j];
                end
            end
        end
    end

    // lane l carries element k on step l+k, zero bubbles otherwise
    always_comb begin
        a_edge = '0;
        b_edge = '0;
        for (int l = 0; l < N; l++) begin
            for (int k = 0; k < N; k++) begin
                if (run && (int'(step) == l + k)) begin
                    a_edge[l] = a_q[l][k];
                    b_edge[l] = bt_q[l][k];
                end
            end
        end
    end

endmodule

// File: rtl/sysmm_array.sv
module sysmm_array
    import sysmm_pkg::*;
#(
    parameter  int N  = DIM_DEF,
    parameter  int W  = ELEM_W_DEF,
    localparam int AW = acc_width(W, N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [N*N*W-1:0]    a_flat,
    input  logic [N*N*W-1:0]    b_flat,
    output logic                busy,
    output logic                done,
    output logic [N*N*AW-1:0]   c_flat
);
    ctrl_s              ctl;
    logic [N-1:0][W-1:0] a_edge;
    logic [N-1:0][W-1:0] b_edge;

    // operand seen by cell (i,j)
    logic [W-1:0]  a_op [N][N];
    logic [W-1:0]  b_op [N][N];
    logic [AW-1:0] acc  [N][N];

    sysmm_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl)
    );

    sysmm_feeder #(.N(N), .W(W)) u_feed (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.clear),
        .run    (ctl.busy),
        .step   (ctl.step),
        .a_flat (a_flat),
        .b_flat (b_flat),
        .a_edge (a_edge),
        .b_edge (b_edge)
    );

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (j == 0) begin : g_a_edge
                assign a_op[i][j] = a_edge[i];
            end else begin : g_a_link
                always_ff @(posedge clk) begin
                    if (rst || ctl.clear) a_op[i][j] <= '0;
                    else                  a_op[i][j] <= a_op[i][j-1];
                end
            end
            if (i == 0) begin : g_b_edge
                assign b_op[i][j] = b_edge[j];
            end else begin : g_b_link
                always_ff @(posedge clk) begin
                    if (rst || ctl.clear) b_op[i][j] <= '0;
                    else                  b_op[i][j] <= b_op[i-1][j];
                end
            end

            sysmm_pe #(.W(W), .AW(AW)) u_pe (
                .clk  (clk),
                .rst  (rst),
                .clr  (ctl.clear),
                .en   (ctl.busy),
                .a_in (a_op[i][j]),
                .b_in (b_op[i][j]),
                .acc  (acc[i][j])
            );

            assign c_flat[(i*N+j)*AW +: AW] = acc[i][j];
        end
    end

    assign busy = ctl.busy;
    assign done = ctl.done;

endmodule

module sysmm_array_chk
    import sysmm_pkg::*;
#(
    parameter int N = 3,
    parameter int W = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          start,
    input logic                          busy,
    input logic                          done,
    input logic [N*N*acc_width(W,N)-1:0] c_flat
);
    localparam int RUNC = run_cycles(N);

    logic [7:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)                 cyc <= '0;
        else if (start && !busy) cyc <= '0;
        else if (busy)           cyc <= cyc + 8'd1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && c_flat == '0));

    a_r4_cleared_on_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (c_flat == '0));

    a_r5_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cyc == 8'(RUNC)));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    a_r6_end_to_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r7_hold_results: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(c_flat));

endmodule

bind sysmm_array sysmm_array_chk #(.N(N), .W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .c_flat (c_flat)
);

// File: tb/tb_sysmm_array.sv
module tb_sysmm_array;
    localparam int N  = 3;
    localparam int W  = 4;
    localparam int AW = 10;
    localparam int EXP_LAT = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [N*N*W-1:0]  a_flat = '0;
    logic [N*N*W-1:0]  b_flat = '0;
    logic              busy;
    logic              done;
    logic [N*N*AW-1:0] c_flat;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    sysmm_array dut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .a_flat (a_flat),
        .b_flat (b_flat),
        .busy   (busy),
        .done   (done),
        .c_flat (c_flat)
    );

    function automatic logic [N*N*AW-1:0] ref_mm(input logic [N*N*W-1:0] a, input logic [N*N*W-1:0] b);
        logic [N*N*AW-1:0] r = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                int s = 0;
                for (int k = 0; k < N; k++)
                    s += int'(a[(i*N+k)*W +: W]) * int'(b[(k*N+j)*W +: W]);
                r[(i*N+j)*AW +: AW] = AW'(s);
            end
        end
        return r;
    endfunction

    function automatic logic [N*N*W-1:0] ident();
        logic [N*N*W-1:0] m = '0;
        for (int i = 0; i < N; i++) m[(i*N+i)*W +: W] = W'(1);
        return m;
    endfunction

    function automatic logic [N*N*W-1:0] rand_mat();
        logic [N*N*W-1:0] m;
        for (int e = 0; e < N*N; e++) m[e*W +: W] = W'($urandom_range(0, 15));
        return m;
    endfunction

    function automatic logic [N*N*W-1:0] fill(input int v);
        logic [N*N*W-1:0] m;
        for (int e = 0; e < N*N; e++) m[e*W +: W] = W'(v);
        return m;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    task automatic kick(input logic [N*N*W-1:0] a, input logic [N*N*W-1:0] b);
        @(negedge clk);
        a_flat = a;
        b_flat = b;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_and_check(input string req, input logic [N*N*W-1:0] a, input logic [N*N*W-1:0] b);
        int lat;
        kick(a, b);
        wait_done(lat);
        chk(req, 128'(c_flat), 128'(ref_mm(a, b)));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy", 128'(busy), 128'(0));
        chk("R1 done", 128'(done), 128'(0));
        chk("R1 results", 128'(c_flat), 128'(0));
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_orientation();
        logic [N*N*W-1:0] a;
        a = '0;
        for (int e = 0; e < N*N; e++) a[e*W +: W] = W'(e + 1);
        run_and_check("R2 A times I", a, ident());
        run_and_check("R2 I times B", ident(), a);
        run_and_check("R2 asymmetric", a, fill(2) ^ a);
    endtask

    task automatic t_extremes();
        logic [N*N*AW-1:0] exp;
        for (int e = 0; e < N*N; e++) exp[e*AW +: AW] = AW'(675);
        kick(fill(15), fill(15));
        begin
            int lat;
            wait_done(lat);
        end
        chk("R3 all max 675", 128'(c_flat), 128'(exp));
        run_and_check("R3 zeros", fill(0), rand_mat());
    endtask

    task automatic t_random();
        for (int r = 0; r < 20; r++) begin
            logic [N*N*W-1:0] a = rand_mat();
            logic [N*N*W-1:0] b = rand_mat();
            int lat;
            kick(a, b);
            wait_done(lat);
            chk("R5 latency", 128'(lat), 128'(EXP_LAT));
            chk("R3 random product", 128'(c_flat), 128'(ref_mm(a, b)));
            chk("R6 busy low at done", 128'(busy), 128'(0));
        end
    endtask

    task automatic t_clear();
        kick(fill(7), fill(9));
        chk("R4 cleared first busy cycle", 128'(c_flat), 128'(0));
        chk("R4 busy after accept", 128'(busy), 128'(1));
        begin
            int lat;
            wait_done(lat);
        end
        run_and_check("R4 second run no residue", fill(1), ident());
    endtask

    task automatic t_hold();
        logic [N*N*AW-1:0] snap;
        run_and_check("R7 setup", rand_mat(), rand_mat());
        snap = c_flat;
        a_flat = rand_mat();
        b_flat = rand_mat();
        repeat (6) @(negedge clk);
        chk("R7 results held", 128'(c_flat), 128'(snap));
        chk("R6 done sticky", 128'(done), 128'(1));
    endtask

    task automatic t_start_busy();
        logic [N*N*W-1:0] a = rand_mat();
        logic [N*N*W-1:0] b = rand_mat();
        int lat;
        kick(a, b);
        repeat (2) @(negedge clk);
        a_flat = fill(15);
        b_flat = fill(15);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        lat = 4;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 latency unchanged", 128'(lat), 128'(EXP_LAT));
        chk("R8 first operands kept", 128'(c_flat), 128'(ref_mm(a, b)));
    endtask

    task automatic t_input_change();
        logic [N*N*W-1:0] a = rand_mat();
        logic [N*N*W-1:0] b = rand_mat();
        int lat;
        kick(a, b);
        a_flat = ~a;
        b_flat = ~b;
        wait_done(lat);
        chk("R9 captured operands", 128'(c_flat), 128'(ref_mm(a, b)));
    endtask

    task automatic t_sweep();
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                logic [N*N*AW-1:0] exp;
                int lat;
                for (int e = 0; e < N*N; e++) exp[e*AW +: AW] = AW'(3 * x * y);
                kick(fill(x), fill(y));
                wait_done(lat);
                chk("R10 product sweep", 128'(c_flat), 128'(exp));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R5 watchdog: got no finish expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_orientation();
        t_extremes();
        t_random();
        t_clear();
        t_hold();
        t_start_busy();
        t_input_change();
        t_sweep();
        summary();
        $finish;
    end

endmodule